// File: doc/BRIEF.md
# Sequencer Branch Condition Logic

This block produces the one address bit that a buffer-control microsequencer consults when it takes a conditional branch. The bit is active low. It is pulled low by either of two conditions: a 4-bit branch counter sitting at its terminal value, or a transfer flag that is brought over from the device clock domain. Each condition has its own enable from microcode. When neither enabled condition holds, the bit rests high.

Every microcode control field passes through a register stage before it acts. These fields are clear, load, load-value select, increment, the two branch enables and the device-buffer-address increment. So a control written by the sequencer takes effect one sequencer clock after it is captured.

The transfer flag is owned by a small state machine with three states. `XF_IDLE` means the flag is clear. `XF_ARMED` means the flag is set and no address increment has been seen yet. `XF_DRAIN` means the flag is set, an increment has been seen, and the machine is waiting for the synchronized device signal to fall. The transitions are:
- `XF_IDLE`→`XF_ARMED` when the synchronized signal is high.
- `XF_ARMED`→`XF_DRAIN` on a registered increment while the signal is still high.
- `XF_ARMED`→`XF_IDLE` on a registered increment with the signal already low.
- `XF_DRAIN`→`XF_IDLE` when the signal goes low.

Top module: `seq_branch_cond`

## Requirements
- R1: A synchronous active-high reset clears the counter, the transfer flag and every control register, and leaves `branch_n` high.
- R2: `clr_n` is active low and registered. The counter becomes 0 on the clock edge after the one that captured `clr_n`=0.
- R3: `inc` is registered. While the registered value is 1, the counter advances by one on each clock, wrapping from 15 to 0. While it is 0, the counter holds.
- R4: `ld_n` is active low and registered. A registered load writes 12 when the registered `ld_sel` is 0, and 14 when it is 1.
- R5: Starting from a cleared counter with increment enabled, exactly 15 increments bring the counter to its terminal value 15.
- R6: `branch_n` is low when the counter equals 15 and the registered `cry_en` is 1. With the registered `cry_en` at 0, the terminal value has no effect on `branch_n`.
- R7: `branch_n` is low when the transfer flag is set and the registered `xbr_en` is 1. With the registered `xbr_en` at 0, the flag is ignored.
- R8: `xfer_dev` passes through a two-flop synchronizer. The flag sets on the third clock edge after `xfer_dev` rises, with `xbr_en` already registered high.
- R9: Once set, the flag stays set until a registered `dinc` has been seen and the synchronized `xfer_dev` is low, in either order. It clears on the edge where both hold.
- R10: `branch_n` is high whenever neither enabled condition holds. The two low-driving terms combine as a logical OR.
- R11: Clear has priority over load when both are registered in the same cycle. Load has priority over increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Counter clear, active low |
| inc | input | 1 | Counter increment enable |
| ld_n | input | 1 | Counter load, active low |
| ld_sel | input | 1 | Load value select: 0 gives 12, 1 gives 14 |
| cry_en | input | 1 | Terminal-count branch enable |
| xbr_en | input | 1 | Transfer-flag branch enable |
| dinc | input | 1 | Device buffer address increment |
| xfer_dev | input | 1 | Transfer-data signal from the device clock domain |
| branch_n | output | 1 | Branch-select address bit, active low |

## Verification
The hardest situations to reach from the ports are the two orders in which the transfer flag can be released. In one, the address increment arrives while the device signal is still high, so the machine parks in `XF_DRAIN`. In the other, the device signal falls first and the flag lingers in `XF_ARMED` until an increment arrives. The stimulus drives each order separately and probes `branch_n` one edge before and one edge after the expected release. The counter's internal value is never visible directly. It is inferred by enabling the carry branch and counting the edges until `branch_n` falls, which separates a clear, a load of 12 and a load of 14 even when several controls are registered in the same cycle.

// File: rtl/seq_branch_pkg.sv
package seq_branch_pkg;

    // Registered microcode control fields
    typedef struct packed {
        logic clr_n;
        logic inc;
        logic ld_n;
        logic ld_sel;
        logic cry_en;
        logic xbr_en;
        logic dinc;
    } ctrl_t;

    // Transfer flag states
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_ARMED = 2'd1,
        XF_DRAIN = 2'd2
    } xf_state_t;

endpackage

// File: rtl/branch_ctr.sv
module branch_ctr #(
    parameter int CNT_W   = 4,
    parameter int LOAD_LO = 12,
    parameter int LOAD_HI = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n_q,
    input  logic             ld_n_q,
    input  logic             ld_sel_q,
    input  logic             inc_q,
    output logic [CNT_W-1:0] cnt,
    output logic             at_term
);
    localparam logic [CNT_W-1:0] LD_LO_V = CNT_W'(LOAD_LO);
    localparam logic [CNT_W-1:0] LD_HI_V = CNT_W'(LOAD_HI);
    localparam logic [CNT_W-1:0] TERM_V  = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_nx;

    // Priority: clear, then load, then increment (R11)
    always_comb begin
        if (!clr_n_q)
            cnt_nx = '0;
        else if (!ld_n_q)
            cnt_nx = ld_sel_q ? LD_HI_V : LD_LO_V;
        else if (inc_q)
            cnt_nx = cnt + 1'b1;
        else
            cnt_nx = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_nx;
    end

    assign at_term = (cnt == TERM_V);

endmodule

// File: rtl/xfer_flag.sv
module xfer_flag
    import seq_branch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic xfer_dev,
    input  logic dinc_q,
    output logic xf_sync,
    output logic flag
);
    logic [SYNC_STAGES-1:0] sync_r;
    xf_state_t              st_q, st_nx;

    // Synchronizer chain into the sequencer domain
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_r[0] <= 1'b0;
                    else     sync_r[0] <= xfer_dev;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_r[g] <= 1'b0;
                    else     sync_r[g] <= sync_r[g-1];
                end
            end
        end
    endgenerate

    assign xf_sync = sync_r[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= XF_IDLE;
        else     st_q <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            XF_IDLE:  if (xf_sync) st_nx = XF_ARMED;
            XF_ARMED: if (dinc_q)  st_nx = xf_sync ? XF_DRAIN : XF_IDLE;
            XF_DRAIN: if (!xf_sync) st_nx = XF_IDLE;
            default:  st_nx = XF_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (st_q)
            XF_ARMED, XF_DRAIN: flag = 1'b1;
            default:            flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/seq_branch_cond.sv
module seq_branch_cond
    import seq_branch_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int LOAD_LO     = 12,
    parameter int LOAD_HI     = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic inc,
    input  logic ld_n,
    input  logic ld_sel,
    input  logic cry_en,
    input  logic xbr_en,
    input  logic dinc,
    input  logic xfer_dev,
    output logic branch_n
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_val;
    logic             at_term;
    logic             xf_sync;
    logic             xf_flag;

    // Control register stage (R1: reset to inactive levels)
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{clr_n: 1'b1, inc: 1'b0, ld_n: 1'b1, ld_sel: 1'b0,
                        cry_en: 1'b0, xbr_en: 1'b0, dinc: 1'b0};
        end else begin
            ctrl_q <= '{clr_n: clr_n, inc: inc, ld_n: ld_n, ld_sel: ld_sel,
                        cry_en: cry_en, xbr_en: xbr_en, dinc: dinc};
        end
    end

    branch_ctr #(
        .CNT_W  (CNT_W),
        .LOAD_LO(LOAD_LO),
        .LOAD_HI(LOAD_HI)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clr_n_q (ctrl_q.clr_n),
        .ld_n_q  (ctrl_q.ld_n),
        .ld_sel_q(ctrl_q.ld_sel),
        .inc_q   (ctrl_q.inc),
        .cnt     (cnt_val),
        .at_term (at_term)
    );

    xfer_flag #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_xf (
        .clk     (clk),
        .rst     (rst),
        .xfer_dev(xfer_dev),
        .dinc_q  (ctrl_q.dinc),
        .xf_sync (xf_sync),
        .flag    (xf_flag)
    );

    // Either enabled condition pulls the bit low (R6, R7, R10)
    assign branch_n = ~((at_term & ctrl_q.cry_en) | (xf_flag & ctrl_q.xbr_en));

endmodule

// File: rtl/seq_branch_cond_chk.sv
module seq_branch_cond_chk #(
    parameter int CNT_W   = 4,
    parameter int LOAD_LO = 12,
    parameter int LOAD_HI = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_n_q,
    input logic             inc_q,
    input logic             ld_n_q,
    input logic             ld_sel_q,
    input logic             dinc_q,
    input logic [CNT_W-1:0] cnt_val,
    input logic             xf_sync,
    input logic             xf_flag
);
    // R2: a registered clear zeroes the counter on the next edge
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        !clr_n_q |=> (cnt_val == '0));

    // R4 / R11: a registered load without clear writes the selected value
    a_r4_load_value: assert property (@(posedge clk) disable iff (rst)
        (clr_n_q && !ld_n_q) |=>
            (cnt_val == (($past(ld_sel_q)) ? CNT_W'(LOAD_HI) : CNT_W'(LOAD_LO))));

    // R3: increment advances by one, wrapping
    a_r3_advance: assert property (@(posedge clk) disable iff (rst)
        (clr_n_q && ld_n_q && inc_q) |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

    // R3: no control leaves the counter unchanged
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (clr_n_q && ld_n_q && !inc_q) |=> $stable(cnt_val));

    // R8: synchronized transfer signal sets the flag
    a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        (!xf_flag && xf_sync) |=> xf_flag);

    // R9: without a registered increment the flag holds
    a_r9_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (xf_flag && !dinc_q && xf_sync) |=> xf_flag);
endmodule

bind seq_branch_cond seq_branch_cond_chk #(
    .CNT_W  (CNT_W),
    .LOAD_LO(LOAD_LO),
    .LOAD_HI(LOAD_HI)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .clr_n_q (ctrl_q.clr_n),
    .inc_q   (ctrl_q.inc),
    .ld_n_q  (ctrl_q.ld_n),
    .ld_sel_q(ctrl_q.ld_sel),
    .dinc_q  (ctrl_q.dinc),
    .cnt_val (cnt_val),
    .xf_sync (xf_sync),
    .xf_flag (xf_flag)
);

// File: tb/seq_branch_cond_tb_top.sv
module seq_branch_cond_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_n = 1'b1, inc = 1'b0, ld_n = 1'b1, ld_sel = 1'b0;
    logic cry_en = 1'b0, xbr_en = 1'b0, dinc = 1'b0, xfer_dev = 1'b0;
    logic branch_n;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    seq_branch_cond dut_i (
        .clk(clk), .rst(rst), .clr_n(clr_n), .inc(inc), .ld_n(ld_n),
        .ld_sel(ld_sel), .cry_en(cry_en), .xbr_en(xbr_en), .dinc(dinc),
        .xfer_dev(xfer_dev), .branch_n(branch_n)
    );

    // Advance n edges, then settle 1 ns after the last edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (branch_n !== exp) begin
            fails++;
            $display("FAIL %s branch_n actual=%b expected=%b", req, branch_n, exp);
        end
    endtask

    task automatic idle_ctrls();
        clr_n = 1'b1; inc = 1'b0; ld_n = 1'b1; ld_sel = 1'b0;
        cry_en = 1'b0; xbr_en = 1'b0; dinc = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; idle_ctrls(); xfer_dev = 1'b0;
        tick(3);
        check("R1 reset", 1'b1);
        rst = 1'b0;
        tick(1);
        check("R1 after reset", 1'b1);
    endtask

    // Clear, then count with carry branch enabled: 15 increments to terminal
    task automatic t_clear_count();
        clr_n = 1'b0; tick(1);
        clr_n = 1'b1; cry_en = 1'b1; inc = 1'b1; tick(1);
        check("R2 cleared", 1'b1);
        for (int k = 1; k <= 14; k++) begin
            tick(1);
            if (k == 1 || k == 14) check("R5 below terminal", 1'b1);
        end
        tick(1);
        check("R5 terminal after 15", 1'b0);
        check("R6 carry branch", 1'b0);
        tick(1);
        check("R3 wrap to 0", 1'b1);
        idle_ctrls();
        tick(2);
    endtask

    // Counter holds while increment is low
    task automatic t_hold();
        clr_n = 1'b0; tick(1);
        clr_n = 1'b1; cry_en = 1'b1; tick(20);
        check("R3 hold at 0", 1'b1);
        inc = 1'b1; tick(15);
        check("R3 one short", 1'b1);
        tick(1);
        check("R3 terminal", 1'b0);
        idle_ctrls(); tick(2);
    endtask

    task automatic t_load(input logic sel, input int steps);
        cry_en = 1'b1;
        ld_n = 1'b0; ld_sel = sel; tick(1);
        ld_n = 1'b1; inc = 1'b1; tick(1);
        for (int k = 0; k < steps; k++) begin
            check(sel ? "R4 load 14 below terminal" : "R4 load 12 below terminal", 1'b1);
            tick(1);
        end
        check(sel ? "R4 load 14 terminal" : "R4 load 12 terminal", 1'b0);
        idle_ctrls(); tick(2);
    endtask

    task automatic t_priority();
        cry_en = 1'b1;
        clr_n = 1'b0; ld_n = 1'b0; ld_sel = 1'b1; inc = 1'b1; tick(1);
        clr_n = 1'b1; ld_n = 1'b1; inc = 1'b0; tick(1);
        inc = 1'b1; tick(15);
        check("R11 clear beats load", 1'b1);
        tick(1);
        check("R11 clear beats load terminal", 1'b0);
        inc = 1'b0; tick(2);
        ld_n = 1'b0; ld_sel = 1'b1; inc = 1'b1; tick(1);
        ld_n = 1'b1; inc = 1'b0; tick(1);
        check("R11 load beats inc", 1'b1);
        inc = 1'b1; tick(1);
        check("R11 load beats inc hold", 1'b1);
        tick(1);
        check("R11 load beats inc terminal", 1'b0);
        idle_ctrls(); tick(2);
    endtask

    task automatic t_cry_gate();
        ld_n = 1'b0; ld_sel = 1'b1; tick(1);
        ld_n = 1'b1; inc = 1'b1; tick(1);
        inc = 1'b0; tick(1);
        check("R6 terminal ignored when disabled", 1'b1);
        cry_en = 1'b1; tick(1);
        check("R6 terminal enabled", 1'b0);
        cry_en = 1'b0; tick(1);
        check("R10 no enabled condition", 1'b1);
        clr_n = 1'b0; tick(1);
        idle_ctrls(); tick(2);
    endtask

    // Flag release with increment first, then device signal drop
    task automatic t_xfer_inc_first();
        xbr_en = 1'b1; xfer_dev = 1'b1; tick(2);
        check("R8 not yet synchronized", 1'b1);
        tick(1);
        check("R8 flag set third edge", 1'b0);
        xbr_en = 1'b0; tick(1);
        check("R7 flag ignored when disabled", 1'b1);
        xbr_en = 1'b1; tick(1);
        check("R7 flag branch", 1'b0);
        dinc = 1'b1; tick(1);
        dinc = 1'b0; tick(1);
        check("R9 still set while signal high", 1'b0);
        xfer_dev = 1'b0; tick(2);
        check("R9 before release", 1'b0);
        tick(1);
        check("R9 released after drop", 1'b1);
        idle_ctrls(); tick(2);
    endtask

    // Flag release with device signal drop first, then increment
    task automatic t_xfer_drop_first();
        xbr_en = 1'b1; xfer_dev = 1'b1; tick(3);
        xfer_dev = 1'b0; tick(10);
        check("R9 holds without increment", 1'b0);
        dinc = 1'b1; tick(1);
        dinc = 1'b0;
        check("R9 before increment acts", 1'b0);
        tick(1);
        check("R9 released after increment", 1'b1);
        idle_ctrls(); tick(2);
    endtask

    initial begin
        t_reset();
        t_clear_count();
        t_hold();
        t_load(1'b0, 3);
        t_load(1'b1, 1);
        t_priority();
        t_cry_gate();
        t_xfer_inc_first();
        t_xfer_drop_first();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule